// File: doc/BRIEF.md
# Two-Level Security Way-Partitioned Cache

This block is a small set-associative tag-and-data array. At build time its ways are split into two fixed groups. Ways `0 .. HI_WAYS-1` of every set form the high-security group, and the remaining ways form the low-security group. Every request carries a one-bit security label along with its word address, a write flag and write data.

A high-labelled request sees every line in the set. A low-labelled request sees only the low group. Misses allocate only inside the requester's own group, and each group has its own round-robin pointer per set. When a low-labelled request misses but finds its address held in the high group, the line is moved into a low way and the high copy is dropped. No memory read takes place in that case. Each line holds one data word. A single request/response port to backing memory serves write-backs of dirty victims and line fills.

The control is a six-state machine:

- **IDLE** accepts a request (`req_valid && req_ready`) and moves to **LOOK**.
- **LOOK** probes the set.
  - A visible hit responds in that cycle and returns to **IDLE**.
  - On a miss, a dirty victim sends the machine to **EVICT**.
  - Otherwise a migration goes to **DONE**, and a plain miss goes to **READ**.
- **EVICT** holds a write-back until memory takes it. It then goes to **DONE** for a migration or to **READ** otherwise.
- **READ** holds the line read until it is taken, then goes to **WAIT**.
- **WAIT** waits for the memory response, then goes to **DONE**.
- **DONE** installs the line, applies a pending write, responds and returns to **IDLE**.

Top module: `wpart_cache`

## Requirements
- R1: The split is fixed. Ways below `HI_WAYS` are high and the rest are low. A high-labelled miss fills and evicts only high ways, and a low-labelled miss only low ways, so lines in one group are never displaced by a request with the other label.
- R2: A high-labelled request (`req_high`=1) hits on a matching valid line in either group.
- R3: A low-labelled request (`req_high`=0) hits only on low-group lines. A matching line held in the high group is treated as a miss.
- R4: On a low-labelled miss whose address is resident in the high group, the line is moved into the low victim way with its data and dirty state, the high copy is invalidated, and no memory read is issued.
- R5: Each set keeps one round-robin pointer per group, starting at the group's first way after reset. The victim is the pointed way, and the pointer advances, wrapping inside its group, only when a line is installed into that group, migrations included.
- R6: A victim that is valid and dirty is written back to memory at its own line address before any fill read is issued. Clean victims produce no write, and all memory traffic of a request completes before its response.
- R7: A visible hit raises `rsp_valid` in the cycle after acceptance. Reads return the line data; writes return the written data.
- R8: `req_ready` is low from the acceptance of a request until its response, so at most one request is in flight.
- R9: After reset every line is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R10: Once raised, `mem_req_valid` and the memory request fields stay unchanged until `mem_req_ready` is seen.
- R11: A write hit marks the line dirty. A line filled from memory is clean unless the request that caused the fill was a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_high | input | 1 | Security label, 1 = high, 0 = low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low SET_W bits select the set |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, or the written data for a write |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | ADDR_W | Memory line address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
The hardest case to reach is the write-back of a line that was dirtied in the high group, then migrated, and only later evicted from the low group. Reaching it needs a chain of requests on one set:

1. A high write miss places the line in the high group and makes it dirty.
2. A low read of the same address migrates the line into a low way.
3. Further low misses rotate the low pointer back onto that way.
4. One more low miss evicts it and forces the write-back.

The bench walks that chain on purpose. It checks that the write-back address and data match the original write, and that no read appears for the migration. It then runs long runs of mixed-label traffic over a small address range with randomly stalled memory, so that migrations and dirty evictions occur often. A behavioural model predicts every response, every memory transaction and each hit's one-cycle latency.

// File: rtl/wpart_pkg.sv
package wpart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVICT,
        ST_READ,
        ST_WAIT,
        ST_DONE
    } wp_state_e;

    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wpart_lookup.sv
module wpart_lookup #(
    parameter int WAYS    = 4,
    parameter int HI_WAYS = 2,
    parameter int TAG_W   = 8
) (
    input  logic [WAYS-1:0]            line_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]           probe_tag,
    input  logic                       probe_high,
    output logic [WAYS-1:0]            match_vec,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way,
    output logic                       shadow,
    output logic [$clog2(WAYS)-1:0]    shadow_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0] vis_vec;
    logic [WAYS-1:0] hid_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam bit IN_HI = (w < HI_WAYS);
        assign match_vec[w] = line_valid[w] && (line_tag[w] == probe_tag);
        // a high line is visible only to a high-labelled probe
        assign vis_vec[w]   = match_vec[w] && (probe_high || !IN_HI);
        assign hid_vec[w]   = match_vec[w] && !probe_high && IN_HI;
    end

    always_comb begin
        hit_way    = '0;
        shadow_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vis_vec[w]) hit_way = WAY_W'(w);
            if (hid_vec[w]) shadow_way = WAY_W'(w);
        end
    end

    assign hit    = |vis_vec;
    assign shadow = |hid_vec;

endmodule

// File: rtl/wpart_rr.sv
module wpart_rr #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int NWAYS = 2,
    parameter int BASE  = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SETS)-1:0]   set_idx,
    input  logic                      advance,
    output logic [$clog2(WAYS)-1:0]   victim
);
    localparam int PTR_W = wpart_pkg::ptr_width(NWAYS);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [PTR_W-1:0] LAST   = PTR_W'(NWAYS - 1);
    localparam logic [WAY_W-1:0] BASE_C = WAY_W'(BASE);

    logic [PTR_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (advance) begin
            ptr_q[set_idx] <= (ptr_q[set_idx] == LAST) ? '0 : ptr_q[set_idx] + 1'b1;
        end
    end

    assign victim = BASE_C + WAY_W'(ptr_q[set_idx]);

endmodule

// File: rtl/wpart_cache.sv
module wpart_cache #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int SETS    = 4,
    parameter int WAYS    = 4,
    parameter int HI_WAYS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_high,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    import wpart_pkg::*;

    localparam int SET_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - SET_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LO_WAYS = WAYS - HI_WAYS;
    localparam logic [WAY_W-1:0] LO_BASE = WAY_W'(HI_WAYS);

    // line storage
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0]             dirty_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];

    // request held for the duration of its service
    wp_state_e          st, st_nx;
    logic               r_high, r_write, r_mig;
    logic [ADDR_W-1:0]  r_addr;
    logic [DATA_W-1:0]  r_wdata, r_fill;
    logic [WAY_W-1:0]   r_victim, r_src;

    logic [SET_W-1:0]   lk_set;
    logic [TAG_W-1:0]   lk_tag;
    logic [WAYS-1:0]    lk_match;
    logic               lk_hit, lk_shadow;
    logic [WAY_W-1:0]   lk_hit_way, lk_shadow_way;
    logic [WAY_W-1:0]   hi_victim, lo_victim, vict_way;
    logic [DATA_W-1:0]  done_data;
    logic               done_dirty;

    assign lk_set = r_addr[SET_W-1:0];
    assign lk_tag = r_addr[ADDR_W-1:SET_W];

    wpart_lookup #(.WAYS(WAYS), .HI_WAYS(HI_WAYS), .TAG_W(TAG_W)) u_lookup (
        .line_valid (valid_q[lk_set]),
        .line_tag   (tag_q[lk_set]),
        .probe_tag  (lk_tag),
        .probe_high (r_high),
        .match_vec  (lk_match),
        .hit        (lk_hit),
        .hit_way    (lk_hit_way),
        .shadow     (lk_shadow),
        .shadow_way (lk_shadow_way)
    );

    wpart_rr #(.SETS(SETS), .WAYS(WAYS), .NWAYS(HI_WAYS), .BASE(0)) u_rr_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (lk_set),
        .advance (st == ST_DONE && r_high),
        .victim  (hi_victim)
    );

    wpart_rr #(.SETS(SETS), .WAYS(WAYS), .NWAYS(LO_WAYS), .BASE(HI_WAYS)) u_rr_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (lk_set),
        .advance (st == ST_DONE && !r_high),
        .victim  (lo_victim)
    );

    // the victim always comes from the requester's own group
    assign vict_way = r_high ? hi_victim : lo_victim;

    // line content installed in DONE
    always_comb begin
        if (r_write)    done_data = r_wdata;
        else if (r_mig) done_data = data_q[lk_set][r_src];
        else            done_data = r_fill;
        done_dirty = r_write || (r_mig && dirty_q[lk_set][r_src]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_nx = ST_LOOK;
            ST_LOOK: begin
                if (lk_hit)                                              st_nx = ST_IDLE;
                else if (valid_q[lk_set][vict_way] && dirty_q[lk_set][vict_way]) st_nx = ST_EVICT;
                else if (lk_shadow)                                      st_nx = ST_DONE;
                else                                                     st_nx = ST_READ;
            end
            ST_EVICT: if (mem_req_ready) st_nx = r_mig ? ST_DONE : ST_READ;
            ST_READ:  if (mem_req_ready) st_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_rdata     = r_write ? r_wdata : data_q[lk_set][lk_hit_way];
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = r_addr;
        mem_req_wdata = data_q[lk_set][r_victim];
        unique case (st)
            ST_IDLE: req_ready = 1'b1;
            ST_LOOK: rsp_valid = lk_hit;
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {tag_q[lk_set][r_victim], lk_set};
            end
            ST_READ: mem_req_valid = 1'b1;
            ST_WAIT: ;
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = done_data;
            end
            default: ;
        endcase
    end

    // request capture and miss bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_high   <= 1'b0;
            r_write  <= 1'b0;
            r_addr   <= '0;
            r_wdata  <= '0;
            r_fill   <= '0;
            r_mig    <= 1'b0;
            r_victim <= '0;
            r_src    <= '0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                r_high  <= req_high;
                r_write <= req_write;
                r_addr  <= req_addr;
                r_wdata <= req_wdata;
            end
            if (st == ST_LOOK && !lk_hit) begin
                r_victim <= vict_way;
                r_mig    <= lk_shadow;
                r_src    <= lk_shadow_way;
            end
            if (st == ST_WAIT && mem_rsp_valid) r_fill <= mem_rsp_rdata;
        end
    end

    // valid and dirty state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (st == ST_LOOK && lk_hit && r_write) dirty_q[lk_set][lk_hit_way] <= 1'b1;
            if (st == ST_DONE) begin
                if (r_mig) begin
                    valid_q[lk_set][r_src] <= 1'b0;
                    dirty_q[lk_set][r_src] <= 1'b0;
                end
                valid_q[lk_set][r_victim] <= 1'b1;
                dirty_q[lk_set][r_victim] <= done_dirty;
            end
        end
    end

    // tags and data carry no reset
    always_ff @(posedge clk) begin
        if (st == ST_LOOK && lk_hit && r_write) data_q[lk_set][lk_hit_way] <= r_wdata;
        if (st == ST_DONE) begin
            tag_q[lk_set][r_victim]  <= lk_tag;
            data_q[lk_set][r_victim] <= done_data;
        end
    end

    // R1
    fill_own_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |-> (r_high ? (r_victim < LO_BASE) : (r_victim >= LO_BASE)));

    // R3
    low_sees_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOK && !r_high && lk_hit) |-> (lk_hit_way >= LO_BASE));

    // R4
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOK) |-> $onehot0(lk_match));

    // R6
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (valid_q[lk_set][r_victim] && dirty_q[lk_set][r_victim]));

    // R7
    hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid == lk_hit));

    // R8
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

endmodule

// File: tb/sim_wpart_cache.sv
`timescale 1ns/1ps
module sim_wpart_cache;
    localparam int AW = 10, DW = 32, NS = 4, NW = 4, NH = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_high = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_req_valid, mem_req_write;
    logic [DW-1:0] rsp_rdata, mem_req_wdata;
    logic [AW-1:0] mem_req_addr;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    always #5 clk = ~clk;

    wpart_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .WAYS(NW), .HI_WAYS(NH)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0, busy = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // behavioural memory and model
    logic [DW-1:0] bmem [1 << AW];
    bit            m_valid [NS][NW];
    bit            m_dirty [NS][NW];
    int            m_tag   [NS][NW];
    logic [DW-1:0] m_data  [NS][NW];
    int            hp [NS];
    int            lp [NS];

    typedef struct { bit wr; int addr; logic [DW-1:0] data; } memop_t;
    memop_t expq [$];

    task automatic model(input bit lab, input bit wr, input int addr, input logic [DW-1:0] wd,
                         output int kind, output logic [DW-1:0] rd);
        int s, t, hitw, hiw, v, n;
        logic [DW-1:0] nd;
        bit ndirty;
        s = addr % NS; t = addr / NS; hitw = -1; hiw = -1;
        for (int w = 0; w < NW; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) begin
                if (lab || w >= NH) hitw = w; else hiw = w;
            end
        if (hitw >= 0) begin
            kind = 0;
            if (wr) begin m_data[s][hitw] = wd; m_dirty[s][hitw] = 1; end
            rd = m_data[s][hitw];
        end else begin
            n = lab ? NH : NW - NH;
            v = lab ? hp[s] : NH + lp[s];
            if (m_valid[s][v] && m_dirty[s][v])
                expq.push_back('{1, m_tag[s][v] * NS + s, m_data[s][v]});
            if (hiw >= 0) begin
                kind = 1; nd = m_data[s][hiw]; ndirty = m_dirty[s][hiw];
                m_valid[s][hiw] = 0; m_dirty[s][hiw] = 0;
            end else begin
                kind = 2; nd = bmem[addr]; ndirty = 0;
                expq.push_back('{0, addr, '0});
            end
            if (wr) begin nd = wd; ndirty = 1; end
            m_valid[s][v] = 1; m_tag[s][v] = t; m_data[s][v] = nd; m_dirty[s][v] = ndirty;
            if (lab) hp[s] = (hp[s] + 1) % n; else lp[s] = (lp[s] + 1) % n;
            rd = nd;
        end
    endtask

    task automatic req(input bit lab, input bit wr, input int addr, input logic [DW-1:0] wd,
                       input string rq);
        int kind, lat;
        logic [DW-1:0] exp_rd;
        model(lab, wr, addr, wd, kind, exp_rd);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_high = lab; req_write = wr; req_addr = AW'(addr); req_wdata = wd;
        @(negedge clk);
        req_valid = 0; busy = 1; lat = 1;
        while (!rsp_valid && lat < 300) begin @(negedge clk); lat++; end
        busy = 0;
        chk(rsp_valid, rq, "response seen", DW'(rsp_valid), 1);
        chk(rsp_rdata == exp_rd, rq, "response data", rsp_rdata, exp_rd);
        if (kind == 0) chk(lat == 1, rq, "hit latency", DW'(lat), 1);
        else           chk(lat > 1, rq, "miss latency above one", DW'(lat), 2);
        chk(expq.size() == 0, "R6", "memory traffic done before response", DW'(expq.size()), 0);
        @(negedge clk);
    endtask

    // memory responder, driven away from the rising edge
    int stall = 0, rd_cnt = 0;
    bit rd_busy = 0, was_wait = 0;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] rd_data;
    always @(negedge clk) begin
        memop_t op;
        mem_rsp_valid = 0;
        if (mem_req_ready) mem_req_ready = 0;
        else if (mem_req_valid && !rd_busy) begin
            if (was_wait)
                chk(mem_req_addr == hold_addr, "R10", "held request address", DW'(mem_req_addr), DW'(hold_addr));
            if (stall > 0) begin
                stall--; was_wait = 1; hold_addr = mem_req_addr;
            end else begin
                was_wait = 0;
                mem_req_ready = 1;
                if (expq.size() == 0) chk(0, "R6", "unexpected memory request", DW'(mem_req_addr), 0);
                else begin
                    op = expq.pop_front();
                    chk(mem_req_write == op.wr, op.wr ? "R6" : "R4", "memory op kind", DW'(mem_req_write), DW'(op.wr));
                    chk(mem_req_addr == AW'(op.addr), "R6", "memory address", DW'(mem_req_addr), DW'(op.addr));
                    if (op.wr) chk(mem_req_wdata == op.data, "R11", "write-back data", mem_req_wdata, op.data);
                end
                if (mem_req_write) bmem[mem_req_addr] = mem_req_wdata;
                else begin rd_busy = 1; rd_cnt = $urandom_range(0, 3); rd_data = bmem[mem_req_addr]; end
                stall = $urandom_range(0, 2);
            end
        end
        if (rd_busy && !mem_req_ready) begin
            if (rd_cnt == 0) begin mem_rsp_valid = 1; mem_rsp_rdata = rd_data; rd_busy = 0; end
            else rd_cnt--;
        end
    end

    // per-clock check of the single in-flight rule
    always @(negedge clk) if (rst_n && busy) begin
        n_chk++;
        if (req_ready) begin n_fail++; $display("FAIL R8 ready while busy: actual 1 expected 0"); end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) bmem[i] = DW'(i * 40503) ^ 32'h5A5A_0000;
        for (int s = 0; s < NS; s++) begin
            hp[s] = 0; lp[s] = 0;
            for (int w = 0; w < NW; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R9", "ready after reset", DW'(req_ready), 1);
        chk(rsp_valid == 0, "R9", "no response after reset", DW'(rsp_valid), 0);
        chk(mem_req_valid == 0, "R9", "no memory request after reset", DW'(mem_req_valid), 0);

        // set 0: fill, hits across labels, migration, dirty chain
        req(0, 0, 'h10, 0, "R9");              // cold miss
        req(0, 0, 'h10, 0, "R7");              // low hit on low line
        req(1, 0, 'h10, 0, "R2");              // high hit on low line
        req(1, 1, 'h20, 32'hCAFE_0001, "R1");  // high write miss into high way
        req(1, 0, 'h20, 0, "R11");             // dirty high line reads back
        req(0, 0, 'h20, 0, "R3");              // high line hidden: migration
        req(1, 0, 'h20, 0, "R4");              // now found in low group
        req(0, 0, 'h30, 0, "R5");              // low pointer wraps onto 0x10 (clean)
        req(0, 0, 'h40, 0, "R6");              // evicts migrated dirty 0x20
        req(1, 0, 'h50, 0, "R5");
        req(1, 0, 'h60, 0, "R5");
        req(1, 1, 'h50, 32'h0BAD_F00D, "R11"); // write hit marks dirty
        req(0, 1, 'h50, 32'h1234_5678, "R4");  // low write migrates then writes
        req(0, 0, 'h60, 0, "R4");
        req(0, 0, 'h70, 0, "R6");              // writes back the migrated 0x50

        // set 1: high misses never displace a low line
        req(0, 0, 'h11, 0, "R1");
        for (int k = 2; k < 7; k++) req(1, 0, k * 16 + 1, 0, "R1");
        req(0, 0, 'h11, 0, "R1");
        // set 2: low misses never displace a high line
        req(1, 1, 'h12, 32'h00C0_FFEE, "R1");
        for (int k = 2; k < 7; k++) req(0, 0, k * 16 + 2, 0, "R1");
        req(1, 0, 'h12, 0, "R1");
        req(0, 0, 'h12, 0, "R3");

        // mixed traffic
        for (int i = 0; i < 600; i++)
            req(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                $urandom_range(0, 47), $urandom, "R7");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule